// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

A bank of 32 general-purpose I/O lines behind a small memory-mapped register port. Software picks each line's direction, drives output values, and can set an output line to blink at a fixed rate. Input lines pass through a two-flop synchroniser. A per-line polarity bit then optionally inverts them. Software reads the adjusted value as the data-in register.

The adjusted input feeds both interrupt paths. A 0-to-1 step of that value latches a sticky edge-cause bit. Software clears a cause bit by writing a zero to it. Level requests come straight from the adjusted value. Each line's request is gated by its own edge and level enable bits. The requests are then ORed in groups of eight lines onto four summary interrupt outputs.

Top module: `pin_bank`

## Requirements
- R1: After reset, the direction register reads all ones (every line is an input) and pad_oe is zero. Data-out, blink, polarity, edge cause, edge mask and level mask all read zero, and irq_grp is zero.
- R2: Direction bit 1 makes the line an input with pad_oe low. Bit 0 drives pad_oe high and, with blink off, pad_out follows the data-out bit.
- R3: Data-in (offset 0x10, read-only) returns the pin value after two synchroniser flops, XORed with the polarity bit (offset 0x0C). Polarity 1 inverts the line.
- R4: A 0-to-1 transition of a line's adjusted input sets its edge-cause bit (offset 0x14). With polarity 0 this catches rising pin edges, and with polarity 1 it catches falling pin edges.
- R5: A polarity write that moves the adjusted value of a steady pin from 0 to 1 sets the cause bit. A write that moves it from 1 to 0 does not.
- R6: A write to the edge-cause register clears each bit written as 0 and keeps each bit written as 1. Cause bits stay set until cleared this way.
- R7: When a new edge arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R8: The request of line i is (data-in[i] AND level-mask[i]) OR (cause[i] AND edge-mask[i]). The level mask is at 0x1C and the edge mask is at 0x18.
- R9: irq_grp[g] is the OR of the requests of lines 8g to 8g+7, for g = 0..3.
- R10: An output line with its blink bit set (offset 0x08) toggles pad_out every BLINK_DIV clock cycles, regardless of its data-out bit. Lines with blink clear follow data-out (offset 0x00).
- R11: Data-out, direction (0x04), blink, polarity and both masks read back the last value written. A write to data-in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pin inputs |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Per-line output enable, 1 drives the pin |
| irq_grp | output | 4 | Summary interrupts, one per eight lines |

## Verification
A wrong synchroniser or polarity state shows up in the data-in read and on the level-driven irq_grp two cycles after the pin changes. A lost or spurious edge shows up as a wrong cause read and an irq_grp mismatch one cycle later. Those outputs stay wrong until software writes the cause register. A bad clear mask or a wrong set-versus-clear priority is therefore visible on the next read of the cause register. A wrong blink prescaler appears as a pad_out toggle interval that differs from BLINK_DIV at the first full period.

// File: rtl/pin_bank_pkg.sv
// Shared constants for the GPIO bank: register word indices and defaults.
// Assumes 32-bit registers placed on 4-byte boundaries.
package pin_bank_pkg;
    localparam int LINES_DEF    = 32;
    localparam int GRP_SIZE_DEF = 8;
    localparam int BLINK_DEF    = 16;
    localparam int ADDR_W       = 5;

    typedef enum logic [2:0] {
        REG_DOUT  = 3'd0,
        REG_DIR   = 3'd1,
        REG_BLINK = 3'd2,
        REG_POL   = 3'd3,
        REG_DIN   = 3'd4,
        REG_CAUSE = 3'd5,
        REG_EMASK = 3'd6,
        REG_LMASK = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/pin_sync_edge.sv
// Per-line input path: two-flop synchroniser, polarity XOR, rising detector.
// Assumes pad_in is asynchronous; the adjusted value is combinational from
// the second sync flop and the current polarity register.
module pin_sync_edge #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pad_in,
    input  logic [LINES-1:0] pol,
    output logic [LINES-1:0] din,
    output logic [LINES-1:0] edge_evt
);
    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] prev_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // two-flop synchroniser for one line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pad_in[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    // polarity-adjusted input seen by software and detectors
    assign din = sync_q ^ pol;

    // previous adjusted value, used for rising detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    // one-cycle pulse on every 0-to-1 step of the adjusted value
    assign edge_evt = din & ~prev_q;
endmodule

// File: rtl/pin_blink_gen.sv
// Free-running prescaler producing a square wave for blinking outputs.
// Assumes DIV >= 2; the phase flips once every DIV cycles.
module pin_blink_gen #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          tick;

    assign tick = (cnt_q == LAST);

    // prescaler count, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // phase toggles on each wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= 1'b0;
        else if (tick) phase <= ~phase;
    end

    // R10: every wrap flips the output phase
    p_blink_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase != $past(phase)));
endmodule

// File: rtl/pin_irq_merge.sv
// Sticky edge-cause register plus per-line request and group OR tree.
// Assumes edge_evt is a single-cycle pulse; set wins over write-zero clear.
module pin_irq_merge #(
    parameter int LINES    = 32,
    parameter int GRP_SIZE = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LINES-1:0]          edge_evt,
    input  logic                      cause_we,
    input  logic [LINES-1:0]          cause_wdata,
    input  logic [LINES-1:0]          din,
    input  logic [LINES-1:0]          lvl_mask,
    input  logic [LINES-1:0]          edge_mask,
    output logic [LINES-1:0]          cause,
    output logic [LINES/GRP_SIZE-1:0] irq_grp
);
    localparam int NGRP = LINES / GRP_SIZE;

    logic [LINES-1:0] keep;
    logic [LINES-1:0] req;

    assign keep = cause_we ? cause_wdata : '1;

    // sticky cause: zeros written clear, new edges always set
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & keep) | edge_evt;
    end

    assign req = (din & lvl_mask) | (cause & edge_mask);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_grp[g] = |req[g*GRP_SIZE +: GRP_SIZE];
    end

    // R6: without a write, no cause bit drops
    p_cause_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_we |=> ((cause & $past(cause)) == $past(cause)));
    // R6: a write with no edge leaves exactly the surviving bits
    p_cause_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_we && edge_evt == '0) |=> (cause == $past(cause & cause_wdata)));
    // R7: an edge is never lost, even under a clearing write
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |=> ((cause & $past(edge_evt)) == $past(edge_evt)));
endmodule

// File: rtl/pin_bank.sv
// GPIO bank top: register file, read mux, pad drive and interrupt outputs.
// Assumes single-cycle writes and a combinational read of bus_addr.
module pin_bank
    import pin_bank_pkg::*;
#(
    parameter int LINES     = LINES_DEF,
    parameter int GRP_SIZE  = GRP_SIZE_DEF,
    parameter int BLINK_DIV = BLINK_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [LINES-1:0]          pad_in,
    output logic [LINES-1:0]          pad_out,
    output logic [LINES-1:0]          pad_oe,
    output logic [LINES/GRP_SIZE-1:0] irq_grp
);
    localparam int NGRP = LINES / GRP_SIZE;

    logic [LINES-1:0] dout_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [LINES-1:0] din, edge_evt, cause;
    logic [LINES-1:0] wd;
    logic             phase;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_idx_e r);
        return a == {r, 2'b00};
    endfunction

    assign wd = bus_wdata[LINES-1:0];

    // software-writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (bus_we) begin
            if (hit(bus_addr, REG_DOUT))  dout_q  <= wd;
            if (hit(bus_addr, REG_DIR))   dir_q   <= wd;
            if (hit(bus_addr, REG_BLINK)) blink_q <= wd;
            if (hit(bus_addr, REG_POL))   pol_q   <= wd;
            if (hit(bus_addr, REG_EMASK)) emask_q <= wd;
            if (hit(bus_addr, REG_LMASK)) lmask_q <= wd;
        end
    end

    pin_sync_edge #(.LINES(LINES)) i_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pol(pol_q),
        .din(din), .edge_evt(edge_evt)
    );

    pin_blink_gen #(.DIV(BLINK_DIV)) i_blink (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    pin_irq_merge #(.LINES(LINES), .GRP_SIZE(GRP_SIZE)) i_irq (
        .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt),
        .cause_we(bus_we && hit(bus_addr, REG_CAUSE)), .cause_wdata(wd),
        .din(din), .lvl_mask(lmask_q), .edge_mask(emask_q),
        .cause(cause), .irq_grp(irq_grp)
    );

    // pad drive: blink overrides data-out, direction gates the driver
    assign pad_out = (dout_q & ~blink_q) | (blink_q & {LINES{phase}});
    assign pad_oe  = ~dir_q;

    // read mux by register index
    always_comb begin
        bus_rdata = '0;
        case (reg_idx_e'(bus_addr[ADDR_W-1:2]))
            REG_DOUT:  bus_rdata[LINES-1:0] = dout_q;
            REG_DIR:   bus_rdata[LINES-1:0] = dir_q;
            REG_BLINK: bus_rdata[LINES-1:0] = blink_q;
            REG_POL:   bus_rdata[LINES-1:0] = pol_q;
            REG_DIN:   bus_rdata[LINES-1:0] = din;
            REG_CAUSE: bus_rdata[LINES-1:0] = cause;
            REG_EMASK: bus_rdata[LINES-1:0] = emask_q;
            REG_LMASK: bus_rdata[LINES-1:0] = lmask_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: a direction write sets the pad enables to its complement
    p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit(bus_addr, REG_DIR)) |=> (pad_oe == ~$past(wd)));
    // R9: with both masks clear no summary interrupt can be raised
    p_grp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (irq_grp == '0));
    // R1: the cycle after reset, all lines are inputs
    p_reset_dir_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0));
endmodule

// File: tb/test_pin_bank.sv
`timescale 1ns/1ps
module test_pin_bank;
    localparam int DIV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic [3:0]  irq_grp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pin_bank #(.BLINK_DIV(DIV)) i_pin_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
    );

    localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_BLINK = 5'h08,
        A_POL = 5'h0C, A_DIN = 5'h10, A_CAUSE = 5'h14, A_EMASK = 5'h18,
        A_LMASK = 5'h1C;

    // vector: pad, polarity, level mask, expected data-in, expected irq
    localparam int NV = 6;
    localparam logic [131:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
        {32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0001},
        {32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 4'b0010},
        {32'h0100_0000, 32'h0000_0000, 32'h00FF_FFFF, 32'h0100_0000, 4'b0000},
        {32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 4'b1000},
        {32'h00FF_0000, 32'h0000_FF00, 32'h0001_0100, 32'h00FF_FF00, 4'b0110}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic        p0;
        int          gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_DIR, r);   check("R1 dir", r, 32'hFFFF_FFFF);
        rd(A_DOUT, r);  check("R1 dout", r, 0);
        rd(A_CAUSE, r); check("R1 cause", r, 0);
        rd(A_LMASK, r); check("R1 lmask", r, 0);
        check("R1 oe", pad_oe, 0);
        check("R1 irq", {28'd0, irq_grp}, 0);

        // R3 R8 R9: vector walk over level paths
        for (int v = 0; v < NV; v++) begin
            pad_in = VEC[v][131:100];
            wr(A_POL, VEC[v][99:68]);
            wr(A_LMASK, VEC[v][67:36]);
            settle();
            rd(A_DIN, r);
            check($sformatf("R3 din vec%0d", v), r, VEC[v][35:4]);
            check($sformatf("R8 R9 irq vec%0d", v), {28'd0, irq_grp}, {28'd0, VEC[v][3:0]});
        end
        pad_in = '0; wr(A_POL, 0); wr(A_LMASK, 0); settle();
        wr(A_CAUSE, 0);
        rd(A_CAUSE, r); check("R6 cleared", r, 0);

        // R11: readback, data-in write ignored
        wr(A_DOUT, 32'hA5A5_5A5A); rd(A_DOUT, r); check("R11 dout", r, 32'hA5A5_5A5A);
        wr(A_BLINK, 32'h0000_0000); rd(A_BLINK, r); check("R11 blink", r, 0);
        wr(A_EMASK, 32'h1234_5678); rd(A_EMASK, r); check("R11 emask", r, 32'h1234_5678);
        wr(A_DIN, 32'hFFFF_FFFF); rd(A_DIN, r); check("R11 din write ignored", r, 0);
        wr(A_EMASK, 0);

        // R2: direction and output drive
        wr(A_DIR, 32'hFFFF_0000);
        check("R2 oe", pad_oe, 32'h0000_FFFF);
        check("R2 out", pad_out & pad_oe, 32'h0000_5A5A);

        // R4: rising with pol 0 and falling with pol 1
        wr(A_EMASK, 32'h0000_000C);
        pad_in[2] = 1'b1; settle();
        rd(A_CAUSE, r); check("R4 rising", r, 32'h4);
        pad_in[3] = 1'b1; settle();
        wr(A_POL, 32'h8); settle();
        wr(A_CAUSE, 0); settle();
        check("R8 irq after clear", {28'd0, irq_grp}, 0);
        pad_in[3] = 1'b0; settle();
        rd(A_CAUSE, r); check("R4 falling", r, 32'h8);
        check("R9 edge irq grp0", {28'd0, irq_grp}, 32'h1);

        // R5: polarity flips on steady pin 5 (low)
        wr(A_POL, 32'h28); settle();
        rd(A_CAUSE, r); check("R5 flip 0->1", r, 32'h28);
        // R6: write all ones except bit 3
        wr(A_CAUSE, ~32'h8);
        rd(A_CAUSE, r); check("R6 ack one bit", r, 32'h20);
        wr(A_CAUSE, 0);
        wr(A_POL, 32'h08); settle();
        rd(A_CAUSE, r); check("R5 flip 1->0 no cause", r, 0);

        // R7: edge lands in the same cycle as a clearing write
        @(negedge clk); pad_in[6] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = A_CAUSE; bus_we = 1'b1; bus_wdata = 0;
        @(negedge clk); bus_we = 1'b0;
        rd(A_CAUSE, r); check("R7 set beats clear", r, 32'h40);
        wr(A_CAUSE, 0);

        // R10: blink on line 0, line 1 follows data-out
        wr(A_DOUT, 32'h0000_0002);
        wr(A_BLINK, 32'h1);
        @(negedge clk); p0 = pad_out[0];
        for (int k = 0; k < 3*DIV && pad_out[0] == p0; k++) @(negedge clk);
        p0 = pad_out[0]; gap = 0;
        for (int k = 0; k < 3*DIV && pad_out[0] == p0; k++) begin
            @(negedge clk); gap++;
        end
        check("R10 blink interval", gap, DIV);
        check("R10 non-blink follows dout", {31'd0, pad_out[1]}, 1);
        wr(A_BLINK, 0);
        check("R10 blink off follows dout", {31'd0, pad_out[0]}, 0);

        // R1: reset again returns defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_DIR, r); check("R1 dir after re-reset", r, 32'hFFFF_FFFF);
        rd(A_POL, r); check("R1 pol after re-reset", r, 0);

        finish_run();
    end
endmodule